// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block keeps the slot control and slot status registers for a hot-plug capable downstream or root port. Configuration software writes either register through a 16-bit path with byte enables. The block also receives slot events from the platform: a hot-add, a device already present at power-up, and an unplug request. It turns the enabled pending events into one notification level. When that level changes, the block signals it as an MSI-X message, an MSI message or a level INTx line. The enable inputs choose which of the three is used.

Each write to slot control counts as a complete command and sets command-completed at once. Writing 1 to the interlock-control bit toggles the interlock status. If a slot is populated and software writes power-off together with a power indicator of off, the block issues a one-cycle detach request. It refuses add and unplug requests while the interlock is engaged. Power sequencing, message transport and enumeration are handled elsewhere.

Top module: `hpslot_ctrl`

## Requirements
- R1: The reset state of control is: all event enables 0, attention indicator (bits 7:6) = off (2'b11), power-control bit 10 = 0 (power on), and power indicator (bits 9:8) = on (2'b01) when `slot_populated` is 1, else off. Status is 0 except presence-detect state (bit 6), which takes `slot_populated`. The message, INTx, detach and busy outputs are all 0.
- R2: A control write (`cfg_sel`=0) changes only the writable bits (0, 3, 4, 5, 7:6 and, with a power controller, 10:8) and only in the bytes whose byte enable is set. A write with no byte enable set has no effect at all.
- R3: Interlock-control (control bit 11) always reads 0. A control write with byte enable 1 set and bit 11 = 1 toggles interlock status (status bit 7).
- R4: A control write with any byte enable set sets command-completed (status bit 4) on the same clock edge.
- R5: A status write (`cfg_sel`=1, byte enable 0) clears status bits 0 (attention button), 3 (presence changed) and 4 (command completed) where the written bit is 1. A status write leaves every other status bit unchanged.
- R6: The notify level is control bit 5 (hot-plug interrupt enable) AND the OR over bits 0, 3 and 4 of (status AND control).
- R7: An event or control write signals only when the notify level changes. Setting a status event bit that is already 1 gives no new signal.
- R8: Delivery uses MSI-X if `msix_en` is set, else MSI if `msi_en` is set. Either one gives a one-cycle `msg_pulse` with `msg_vec` = `msg_num`. With neither set, `intx` follows the notify level. While either message enable is set, `intx` does not change.
- R9: A status write does not send a message. It updates the stored level, and it drops `intx` only if no message enable is set and the new level is 0.
- R10: A control write with byte enable 1, bit 10 = 1 and bits 9:8 = 2'b11, made while presence-detect state is 1, gives a one-cycle `detach` pulse and clears presence-detect state.
- R11: While interlock status is 1, `add_req` or `unplug_req` gives a one-cycle `busy` pulse and leaves status unchanged.
- R12: `add_req` sets presence-detect state, presence changed and attention button. `add_boot` sets presence-detect state only. `unplug_req` sets attention button.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_populated | input | 1 | Slot holds a device; sampled during reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = slot control, 1 = slot status |
| cfg_be | input | 2 | Byte enables |
| cfg_wdata | input | 16 | Write data |
| add_req | input | 1 | Hot-add of a device |
| add_boot | input | 1 | Device present at power-up (no event) |
| unplug_req | input | 1 | Unplug request (attention button) |
| msix_en | input | 1 | MSI-X delivery enabled |
| msi_en | input | 1 | MSI delivery enabled |
| msg_num | input | VEC_W | Interrupt message number |
| ctl_rdata | output | 16 | Slot control read value |
| sts_rdata | output | 16 | Slot status read value |
| msg_pulse | output | 1 | One-cycle message request |
| msg_vec | output | VEC_W | Vector of the message |
| intx | output | 1 | Level interrupt |
| detach | output | 1 | One-cycle detach request |
| busy | output | 1 | One-cycle refusal of an add or unplug |

## Verification
The hardest case to reach is the silent level change. A status write lowers the level without a message, so the next rising level must produce a pulse even though no falling pulse came before it. To reach it, the stimulus first raises the level through a control write with message delivery on. It then clears the pending bits through the status register and engages the interlock with a second command. That command must produce exactly one new pulse. A refused add is then tried while the lock is held, followed by a power-off detach once the lock is released.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;
    localparam int unsigned REG_W = 16;
    localparam int unsigned NB    = REG_W / 8;

    // control bit positions
    localparam int unsigned C_ABE  = 0;
    localparam int unsigned C_PDE  = 3;
    localparam int unsigned C_CCE  = 4;
    localparam int unsigned C_HPE  = 5;
    localparam int unsigned C_AIND = 6;
    localparam int unsigned C_PIND = 8;
    localparam int unsigned C_POFF = 10;
    localparam int unsigned C_LOCK = 11;

    // status bit positions
    localparam int unsigned S_ABP  = 0;
    localparam int unsigned S_PDC  = 3;
    localparam int unsigned S_CMD  = 4;
    localparam int unsigned S_PRES = 6;
    localparam int unsigned S_LOCK = 7;

    localparam logic [1:0] IND_ON  = 2'b01;
    localparam logic [1:0] IND_OFF = 2'b11;

    localparam logic [REG_W-1:0] EV_MASK =
        REG_W'((1 << S_ABP) | (1 << S_PDC) | (1 << S_CMD));

    typedef enum logic [1:0] {PATH_INTX, PATH_MSI, PATH_MSIX} path_e;

    typedef struct packed {
        logic abp;
        logic pdc;
        logic cmd;
        logic pres;
    } evt_t;

    function automatic logic [REG_W-1:0] ctl_wmask(bit pwr);
        logic [REG_W-1:0] m;
        m = '0;
        m[C_ABE] = 1'b1;
        m[C_PDE] = 1'b1;
        m[C_CCE] = 1'b1;
        m[C_HPE] = 1'b1;
        m[C_AIND +: 2] = 2'b11;
        if (pwr) begin
            m[C_PIND +: 2] = 2'b11;
            m[C_POFF] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] ctl_reset(bit pwr, logic populated);
        logic [REG_W-1:0] r;
        r = '0;
        r[C_AIND +: 2] = IND_OFF;
        r[C_PIND +: 2] = (pwr && populated) ? IND_ON : IND_OFF;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] evt_bits(evt_t e);
        logic [REG_W-1:0] v;
        v = '0;
        v[S_ABP]  = e.abp;
        v[S_PDC]  = e.pdc;
        v[S_CMD]  = e.cmd;
        v[S_PRES] = e.pres;
        return v;
    endfunction

    function automatic path_e pick_path(logic msix, logic msi);
        if (msix) return PATH_MSIX;
        if (msi)  return PATH_MSI;
        return PATH_INTX;
    endfunction
endpackage

// File: rtl/hpslot_regs.sv
module hpslot_regs
    import hpslot_pkg::*;
#(
    parameter bit PWR_CTRL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_populated,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [NB-1:0]    cfg_be,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             add_req,
    input  logic             add_boot,
    input  logic             unplug_req,
    output logic [REG_W-1:0] ctl_q,
    output logic [REG_W-1:0] sts_q,
    output logic [REG_W-1:0] ctl_n,
    output logic [REG_W-1:0] sts_n,
    output logic             clr_path,
    output logic             detach,
    output logic             busy
);
    localparam logic [REG_W-1:0] WMASK = ctl_wmask(PWR_CTRL);

    logic             ctl_wr, sts_wr, locked, refuse, lock_hit, det_n;
    logic [REG_W-1:0] ctl_merge, w1c;
    evt_t             ev;

    assign ctl_wr = cfg_wr && !cfg_sel && (|cfg_be);
    assign sts_wr = cfg_wr &&  cfg_sel && (|cfg_be);
    assign locked = sts_q[S_LOCK];
    assign refuse = (add_req || unplug_req) && locked;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign ctl_merge[b*8 +: 8] = (ctl_wr && cfg_be[b])
            ? ((ctl_q[b*8 +: 8] & ~WMASK[b*8 +: 8]) |
               (cfg_wdata[b*8 +: 8] & WMASK[b*8 +: 8]))
            : ctl_q[b*8 +: 8];
        assign w1c[b*8 +: 8] = (sts_wr && cfg_be[b])
            ? (cfg_wdata[b*8 +: 8] & EV_MASK[b*8 +: 8]) : 8'h00;
    end

    assign lock_hit = ctl_wr && cfg_be[C_LOCK / 8] && cfg_wdata[C_LOCK];
    assign det_n    = ctl_wr && cfg_be[C_POFF / 8] && sts_q[S_PRES] &&
                      cfg_wdata[C_POFF] && (cfg_wdata[C_PIND +: 2] == IND_OFF);

    always_comb begin
        ev.cmd  = ctl_wr;
        ev.abp  = (add_req || unplug_req) && !locked;
        ev.pdc  = add_req && !locked;
        ev.pres = (add_req && !locked) || add_boot;
        ctl_n   = ctl_merge;
        sts_n   = (sts_q | evt_bits(ev)) & ~w1c;
        if (lock_hit) sts_n[S_LOCK] = ~sts_q[S_LOCK];
        if (det_n)    sts_n[S_PRES] = 1'b0;
    end

    assign clr_path = sts_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= ctl_reset(PWR_CTRL, slot_populated);
            sts_q  <= slot_populated ? REG_W'(1 << S_PRES) : '0;
            detach <= 1'b0;
            busy   <= 1'b0;
        end else begin
            ctl_q  <= ctl_n;
            sts_q  <= sts_n;
            detach <= det_n;
            busy   <= refuse;
        end
    end
endmodule

// File: rtl/hpslot_notify.sv
module hpslot_notify
    import hpslot_pkg::*;
#(
    parameter int unsigned VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] ctl_n,
    input  logic [REG_W-1:0] sts_n,
    input  logic             clr_path,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] msg_num,
    output logic             msg_pulse,
    output logic [VEC_W-1:0] msg_vec,
    output logic             intx
);
    logic  lvl_n, lvl_q;
    path_e path;

    assign lvl_n = ctl_n[C_HPE] && (|(ctl_n & sts_n & EV_MASK));
    assign path  = pick_path(msix_en, msi_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q     <= 1'b0;
            msg_pulse <= 1'b0;
            msg_vec   <= '0;
            intx      <= 1'b0;
        end else begin
            msg_pulse <= 1'b0;
            lvl_q     <= lvl_n;
            if (clr_path) begin
                if (path == PATH_INTX && !lvl_n) intx <= 1'b0;
            end else if (lvl_n != lvl_q) begin
                if (path == PATH_INTX) begin
                    intx <= lvl_n;
                end else begin
                    msg_pulse <= 1'b1;
                    msg_vec   <= msg_num;
                end
            end
        end
    end
endmodule

// File: rtl/hpslot_ctrl.sv
module hpslot_ctrl #(
    parameter bit          PWR_CTRL = 1'b1,
    parameter int unsigned VEC_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_populated,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [1:0]       cfg_be,
    input  logic [15:0]      cfg_wdata,
    input  logic             add_req,
    input  logic             add_boot,
    input  logic             unplug_req,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] msg_num,
    output logic [15:0]      ctl_rdata,
    output logic [15:0]      sts_rdata,
    output logic             msg_pulse,
    output logic [VEC_W-1:0] msg_vec,
    output logic             intx,
    output logic             detach,
    output logic             busy
);
    logic [15:0] ctl_n, sts_n;
    logic        clr_path;

    hpslot_regs #(.PWR_CTRL(PWR_CTRL)) u_regs (
        .clk(clk), .rst(rst), .slot_populated(slot_populated),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .add_req(add_req), .add_boot(add_boot),
        .unplug_req(unplug_req), .ctl_q(ctl_rdata), .sts_q(sts_rdata),
        .ctl_n(ctl_n), .sts_n(sts_n), .clr_path(clr_path),
        .detach(detach), .busy(busy)
    );

    hpslot_notify #(.VEC_W(VEC_W)) u_notify (
        .clk(clk), .rst(rst), .ctl_n(ctl_n), .sts_n(sts_n),
        .clr_path(clr_path), .msix_en(msix_en), .msi_en(msi_en),
        .msg_num(msg_num), .msg_pulse(msg_pulse), .msg_vec(msg_vec),
        .intx(intx)
    );
endmodule

// File: rtl/hpslot_ctrl_chk.sv
module hpslot_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic        cfg_sel,
    input logic [1:0]  cfg_be,
    input logic [15:0] cfg_wdata,
    input logic        add_req,
    input logic        unplug_req,
    input logic        msix_en,
    input logic        msi_en,
    input logic [15:0] ctl_rdata,
    input logic [15:0] sts_rdata,
    input logic        msg_pulse,
    input logic        intx,
    input logic        detach,
    input logic        busy
);
    AST_LOCK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[11]); // R3
    AST_CMD_DONE: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_sel && cfg_be != 2'b00) |=> sts_rdata[4]); // R4
    AST_W1C_PDC: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_sel && cfg_be[0] && cfg_wdata[3] && !add_req) |=> !sts_rdata[3]); // R5
    AST_MSG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        msg_pulse |-> $past(msix_en || msi_en)); // R8
    AST_INTX_HELD: assert property (@(posedge clk) disable iff (rst)
        (msix_en || msi_en) |=> $stable(intx)); // R8
    AST_DETACH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        detach |-> !sts_rdata[6]); // R10
    AST_DETACH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        detach |=> !detach); // R10
    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (rst)
        ((add_req || unplug_req) && sts_rdata[7]) |=> busy); // R11
endmodule

bind hpslot_ctrl hpslot_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .add_req(add_req),
    .unplug_req(unplug_req), .msix_en(msix_en), .msi_en(msi_en),
    .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata), .msg_pulse(msg_pulse),
    .intx(intx), .detach(detach), .busy(busy)
);

// File: tb/hpslot_ctrl_test.sv
`timescale 1ns/1ps
module hpslot_ctrl_test;
    localparam int VEC_W = 5;
    localparam int K_CTL = 0, K_STS = 1, K_MSG = 2, K_VEC = 3,
                   K_INTX = 4, K_DET = 5, K_BUSY = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slot_populated = 1'b1;
    logic cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [1:0] cfg_be = '0;
    logic [15:0] cfg_wdata = '0;
    logic add_req = 1'b0, add_boot = 1'b0, unplug_req = 1'b0;
    logic msix_en = 1'b0, msi_en = 1'b0;
    logic [VEC_W-1:0] msg_num = '0;
    logic [15:0] ctl_rdata, sts_rdata;
    logic msg_pulse, intx, detach, busy;
    logic [VEC_W-1:0] msg_vec;

    int n_checks = 0, n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        string       req;
        int          kind;
        logic [15:0] exp;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    hpslot_ctrl #(.PWR_CTRL(1'b1), .VEC_W(VEC_W)) uut (
        .clk(clk), .rst(rst), .slot_populated(slot_populated),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .add_req(add_req), .add_boot(add_boot),
        .unplug_req(unplug_req), .msix_en(msix_en), .msi_en(msi_en),
        .msg_num(msg_num), .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata),
        .msg_pulse(msg_pulse), .msg_vec(msg_vec), .intx(intx),
        .detach(detach), .busy(busy)
    );

    function automatic logic [15:0] observe(int kind);
        case (kind)
            K_CTL:   return ctl_rdata;
            K_STS:   return sts_rdata;
            K_MSG:   return {15'd0, msg_pulse};
            K_VEC:   return 16'(msg_vec);
            K_INTX:  return {15'd0, intx};
            K_DET:   return {15'd0, detach};
            default: return {15'd0, busy};
        endcase
    endfunction

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb.pop_front();
            act = observe(it.kind);
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_v(string req, int kind, logic [15:0] exp);
        sb.push_back('{req, kind, exp});
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cfg_wr = 1'b0; add_req = 1'b0; add_boot = 1'b0; unplug_req = 1'b0;
    endtask

    task automatic ctl_write(logic [1:0] be, logic [15:0] d);
        cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_be = be; cfg_wdata = d;
        tick();
    endtask

    task automatic sts_write(logic [1:0] be, logic [15:0] d);
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_be = be; cfg_wdata = d;
        tick();
    endtask

    task automatic do_reset(logic pop);
        slot_populated = pop;
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        // R1 reset state, populated slot with power controller
        expect_v("R1 ctl", K_CTL, 16'h01C0);
        expect_v("R1 sts", K_STS, 16'h0040);
        expect_v("R1 msg", K_MSG, 16'h0);
        expect_v("R1 intx", K_INTX, 16'h0);
        expect_v("R1 det", K_DET, 16'h0);
        tick();

        // R2 no byte enable: nothing happens, not even a command
        ctl_write(2'b00, 16'hFFFF);
        expect_v("R2 ctl be0", K_CTL, 16'h01C0);
        expect_v("R2 sts be0", K_STS, 16'h0040);

        // R2/R4/R6 low byte only; enables on, level rises, INTx path
        ctl_write(2'b01, 16'hFFFF);
        expect_v("R2 ctl low", K_CTL, 16'h01F9);
        expect_v("R4 cmd", K_STS, 16'h0050);
        expect_v("R6 intx up", K_INTX, 16'h1);
        expect_v("R8 no msg", K_MSG, 16'h0);

        // R5/R9 status clear drops INTx
        sts_write(2'b01, 16'h0010);
        expect_v("R5 w1c", K_STS, 16'h0040);
        expect_v("R9 intx down", K_INTX, 16'h0);

        // R7/R8 MSI path
        msi_en = 1'b1; msg_num = 5'd5;
        ctl_write(2'b01, 16'h00F9);
        expect_v("R8 msi pulse", K_MSG, 16'h1);
        expect_v("R8 msi vec", K_VEC, 16'h0005);
        expect_v("R8 intx held", K_INTX, 16'h0);
        tick();
        expect_v("R8 pulse ends", K_MSG, 16'h0);
        ctl_write(2'b01, 16'h00F9);
        expect_v("R7 no repeat", K_MSG, 16'h0);

        // R12 unplug sets attention button; level unchanged: no message
        unplug_req = 1'b1;
        tick();
        expect_v("R12 unplug", K_STS, 16'h0051);
        expect_v("R7 already high", K_MSG, 16'h0);

        // R9 status clear with MSI-X enabled: silent
        msix_en = 1'b1;
        sts_write(2'b01, 16'h0011);
        expect_v("R5 w1c two", K_STS, 16'h0040);
        expect_v("R9 no msg", K_MSG, 16'h0);

        // R3 interlock toggle, reads zero, R8 MSI-X vector
        msg_num = 5'd9;
        ctl_write(2'b10, 16'h0800);
        expect_v("R3 ctl", K_CTL, 16'h00F9);
        expect_v("R3 lock set", K_STS, 16'h00D0);
        expect_v("R8 msix pulse", K_MSG, 16'h1);
        expect_v("R8 msix vec", K_VEC, 16'h0009);

        // R11 refused add while locked
        add_req = 1'b1;
        tick();
        expect_v("R11 busy", K_BUSY, 16'h1);
        expect_v("R11 sts kept", K_STS, 16'h00D0);
        tick();
        expect_v("R11 busy ends", K_BUSY, 16'h0);

        // R3 unlock
        ctl_write(2'b10, 16'h0800);
        expect_v("R3 lock clear", K_STS, 16'h0050);
        expect_v("R7 still high", K_MSG, 16'h0);

        // R10 power-off detach
        ctl_write(2'b11, 16'h07F9);
        expect_v("R10 detach", K_DET, 16'h1);
        expect_v("R10 pres clear", K_STS, 16'h0010);
        expect_v("R2 ctl both", K_CTL, 16'h07F9);
        tick();
        expect_v("R10 detach ends", K_DET, 16'h0);

        // R12 hot-add
        add_req = 1'b1;
        tick();
        expect_v("R12 add", K_STS, 16'h0059);

        // R8/R9 INTx path again
        msix_en = 1'b0; msi_en = 1'b0;
        sts_write(2'b01, 16'h0019);
        expect_v("R5 w1c all", K_STS, 16'h0040);
        expect_v("R9 intx low", K_INTX, 16'h0);
        add_req = 1'b1;
        tick();
        expect_v("R12 add again", K_STS, 16'h0049);
        expect_v("R8 intx level", K_INTX, 16'h1);
        expect_v("R8 no msg intx", K_MSG, 16'h0);

        // R1 empty slot reset, R12 boot presence, R6 HPIE gating
        do_reset(1'b0);
        expect_v("R1 ctl empty", K_CTL, 16'h03C0);
        expect_v("R1 sts empty", K_STS, 16'h0000);
        expect_v("R1 intx", K_INTX, 16'h0);
        add_boot = 1'b1;
        tick();
        expect_v("R12 boot", K_STS, 16'h0040);
        ctl_write(2'b01, 16'h0010);
        expect_v("R6 no hpie", K_STS, 16'h0050);
        expect_v("R6 intx off", K_INTX, 16'h0);
        ctl_write(2'b01, 16'h0030);
        expect_v("R6 hpie on", K_INTX, 16'h1);
        tick();

        @(negedge clk);
        #1;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule